// File: doc/BRIEF.md
# Parallel Camera Byte Packer

This block sits behind a parallel image-sensor bus and turns the stream of 8-bit samples into 32-bit words for a receive FIFO. The sensor's pixel clock, data bus and line/frame strobes arrive as ordinary signals sampled by the system clock. Pixel-clock transitions are detected in that domain, and the chosen transition captures one byte. Four captured bytes make one word, which is presented with a single-cycle valid strobe.

Several configuration inputs adapt the block to a given sensor:
- which pixel-clock transition captures data;
- whether the pixel clock and the data lines are complemented on entry;
- whether the line strobe qualifies captures, and its active level;
- the order in which bytes fill the word;
- an optional exchange of the word's two 16-bit halves.

A rising frame strobe realigns the packer to a word boundary. Dropping the enable input empties it.

Top module: `cam_pack`

## Requirements
- R1: While reset is held and on the first cycle after it, `word_valid` is 0 and `word_out` is 0.
- R2: With `cfg_rise_edge`=1, a byte is captured at a low-to-high transition of the effective pixel clock. With `cfg_rise_edge`=0, it is captured at a high-to-low transition. The opposite transition captures nothing.
- R3: With `cfg_inv_pclk`=1, the effective pixel clock is the complement of `pclk_in`, so the capturing transition of `pclk_in` is reversed.
- R4: With `cfg_inv_data`=1, each captured byte is the bitwise complement of `data_in`.
- R5: With `cfg_gated`=1, a transition captures a byte only while the line strobe is active. With `cfg_gated`=0, `hsync_in` has no effect.
- R6: The line strobe is active when `hsync_in` equals `cfg_hs_high`: 1 means active high and 0 means active low.
- R7: With `cfg_msb_first`=0, the first byte of a word lands in bits 7:0 and the fourth in bits 31:24. The bytes 0x11, 0x22, 0x33, 0x44 give 0x44332211.
- R8: With `cfg_msb_first`=1, the first byte lands in bits 31:24. The same four bytes give 0x11223344.
- R9: With `cfg_swap16`=1, bits 31:16 and 15:0 of the packed word are exchanged before output, so 0x44332211 becomes 0x22114433.
- R10: A 0-to-1 change of `vsync_in` discards any partial word, so the next captured byte starts a new word. A byte offered in the same cycle as that change is also discarded.
- R11: `word_valid` is 1 for exactly one cycle, in the cycle after the clock edge that captures a word's fourth byte. `word_out` holds its value whenever `word_valid` is 0.
- R12: While `enable` is 0, no byte is captured, any partial word is discarded and `word_valid` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sensor inputs are sampled on its rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Packer enable; 0 holds it empty |
| pclk_in | input | 1 | Sensor pixel clock, as a sampled level |
| data_in | input | 8 | Sensor data bus |
| hsync_in | input | 1 | Line strobe |
| vsync_in | input | 1 | Frame strobe; rising level restarts word alignment |
| cfg_rise_edge | input | 1 | 1: capture on rising effective pixel clock; 0: on falling |
| cfg_inv_pclk | input | 1 | Complement the pixel clock on entry |
| cfg_inv_data | input | 1 | Complement the data lines on entry |
| cfg_gated | input | 1 | Qualify captures with the line strobe |
| cfg_hs_high | input | 1 | Active level of the line strobe |
| cfg_msb_first | input | 1 | 1: first byte into the top byte; 0: into the bottom byte |
| cfg_swap16 | input | 1 | Exchange the word's 16-bit halves |
| word_out | output | 32 | Last completed word |
| word_valid | output | 1 | One-cycle strobe marking a new word |

## Verification
The assertions assume that a sensor sampled in the system-clock domain spaces its pixel-clock transitions at least one system cycle apart. They also assume that the configuration inputs change only while `enable` is low, because a change to the clock inversion alone can create a transition. The stimulus keeps within both assumptions. Every byte is offered as an inactive level followed by an active level, each lasting a full clock cycle. Every configuration change, random or directed, is made inside an enable-low window that also empties the packer.

// File: rtl/cam_pack.sv
module cam_pack #(
  parameter int PIX_W      = 8,
  parameter int WORD_BYTES = 4,
  localparam int WORD_W    = PIX_W * WORD_BYTES,
  localparam int HALF_W    = WORD_W / 2,
  localparam int CNT_W     = (WORD_BYTES > 2) ? $clog2(WORD_BYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              pclk_in,
  input  logic [PIX_W-1:0]  data_in,
  input  logic              hsync_in,
  input  logic              vsync_in,
  input  logic              cfg_rise_edge,
  input  logic              cfg_inv_pclk,
  input  logic              cfg_inv_data,
  input  logic              cfg_gated,
  input  logic              cfg_hs_high,
  input  logic              cfg_msb_first,
  input  logic              cfg_swap16,
  output logic [WORD_W-1:0] word_out,
  output logic              word_valid
);

  logic              pe, pe_q, vs_q;
  logic              take_edge, hs_on, accept, vs_rise, last;
  logic [PIX_W-1:0]  pix;
  logic [CNT_W-1:0]  cnt;
  logic [WORD_W-1:0] acc, acc_next, packed_word;

  assign pe        = pclk_in ^ cfg_inv_pclk;
  assign take_edge = cfg_rise_edge ? (pe & ~pe_q) : (~pe & pe_q);
  assign hs_on     = (hsync_in == cfg_hs_high);
  assign accept    = take_edge & (~cfg_gated | hs_on);
  assign vs_rise   = vsync_in & ~vs_q;
  assign pix       = cfg_inv_data ? ~data_in : data_in;
  assign last      = (cnt == CNT_W'(WORD_BYTES - 1));

  assign acc_next  = cfg_msb_first ? {acc[WORD_W-PIX_W-1:0], pix}
                                   : {pix, acc[WORD_W-1:PIX_W]};
  assign packed_word = cfg_swap16 ? {acc_next[HALF_W-1:0], acc_next[WORD_W-1:HALF_W]}
                                  : acc_next;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pe_q       <= 1'b0;
      vs_q       <= 1'b0;
      cnt        <= '0;
      acc        <= '0;
      word_out   <= '0;
      word_valid <= 1'b0;
    end else begin
      pe_q       <= pe;
      vs_q       <= vsync_in;
      word_valid <= 1'b0;
      if (!enable || vs_rise) begin
        cnt <= '0;
        acc <= '0;
      end else if (accept) begin
        if (last) begin
          cnt        <= '0;
          acc        <= '0;
          word_out   <= packed_word;
          word_valid <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
          acc <= acc_next;
        end
      end
    end
  end

endmodule

// File: rtl/cam_pack_chk.sv
module cam_pack_chk #(
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              hsync_in,
  input logic              vsync_in,
  input logic              cfg_gated,
  input logic              cfg_hs_high,
  input logic [WORD_W-1:0] word_out,
  input logic              word_valid
);

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |=> !word_valid); // R11

  AST_WORD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !word_valid |-> $stable(word_out)); // R11

  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !word_valid); // R12

  AST_GATE_HSYNC: assert property (@(posedge clk) disable iff (!rst_n)
    (word_valid && $past(cfg_gated)) |-> $past(hsync_in == cfg_hs_high)); // R5 R6

  AST_FRAME_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(vsync_in) && enable) |=> !word_valid); // R10

endmodule

bind cam_pack cam_pack_chk #(.WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .hsync_in(hsync_in),
  .vsync_in(vsync_in), .cfg_gated(cfg_gated), .cfg_hs_high(cfg_hs_high),
  .word_out(word_out), .word_valid(word_valid)
);

// File: tb/cam_pack_test.sv
`timescale 1ns/1ps
module cam_pack_test;
  logic clk = 1'b0, rst_n = 1'b0, enable = 1'b0;
  logic pclk_in = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
  logic [7:0] data_in = 8'h00;
  logic cfg_rise_edge = 1'b1, cfg_inv_pclk = 1'b0, cfg_inv_data = 1'b0;
  logic cfg_gated = 1'b0, cfg_hs_high = 1'b1, cfg_msb_first = 1'b0, cfg_swap16 = 1'b0;
  logic [31:0] word_out;
  logic word_valid;

  int nvec = 0, nbad = 0;
  int mcnt = 0;
  logic [31:0] exp_acc = '0, exp_word = '0;
  logic exp_valid = 1'b0;

  always #10 clk = ~clk;

  cam_pack uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .pclk_in(pclk_in), .data_in(data_in),
    .hsync_in(hsync_in), .vsync_in(vsync_in), .cfg_rise_edge(cfg_rise_edge),
    .cfg_inv_pclk(cfg_inv_pclk), .cfg_inv_data(cfg_inv_data), .cfg_gated(cfg_gated),
    .cfg_hs_high(cfg_hs_high), .cfg_msb_first(cfg_msb_first), .cfg_swap16(cfg_swap16),
    .word_out(word_out), .word_valid(word_valid)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s act=%08h exp=%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic pre_level();
    return cfg_rise_edge ? cfg_inv_pclk : ~cfg_inv_pclk;
  endfunction

  task automatic model_clear();
    mcnt = 0;
    exp_acc = '0;
  endtask

  task automatic model_take(input logic [7:0] b);
    logic [7:0] p;
    p = cfg_inv_data ? ~b : b;
    exp_acc = cfg_msb_first ? {exp_acc[23:0], p} : {p, exp_acc[31:8]};
    mcnt++;
    if (mcnt == 4) begin
      exp_valid = 1'b1;
      exp_word  = cfg_swap16 ? {exp_acc[15:0], exp_acc[31:16]} : exp_acc;
      model_clear();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input logic hs, input string tag);
    @(negedge clk);
    chk(word_valid == 1'b0, "R11", {31'd0, word_valid}, 32'd0);
    data_in  = b;
    hsync_in = hs;
    pclk_in  = pre_level();
    @(negedge clk);
    pclk_in = ~pre_level();
    @(negedge clk);
    exp_valid = 1'b0;
    if (enable && (!cfg_gated || hs == cfg_hs_high)) model_take(b);
    chk(word_valid == exp_valid, tag, {31'd0, word_valid}, {31'd0, exp_valid});
    if (exp_valid) chk(word_out == exp_word, tag, word_out, exp_word);
  endtask

  task automatic send4(input logic [31:0] w, input string tag);
    send_byte(w[31:24], cfg_hs_high, tag);
    send_byte(w[23:16], cfg_hs_high, tag);
    send_byte(w[15:8],  cfg_hs_high, tag);
    send_byte(w[7:0],   cfg_hs_high, tag);
  endtask

  task automatic set_cfg(input logic [6:0] c);
    @(negedge clk);
    enable = 1'b0;
    model_clear();
    @(negedge clk);
    {cfg_rise_edge, cfg_inv_pclk, cfg_inv_data, cfg_gated,
     cfg_hs_high, cfg_msb_first, cfg_swap16} = c;
    pclk_in = pre_level();
    repeat (2) @(negedge clk);
    enable = 1'b1;
  endtask

  task automatic frame_pulse();
    @(negedge clk);
    vsync_in = 1'b1;
    @(negedge clk);
    chk(word_valid == 1'b0, "R10", {31'd0, word_valid}, 32'd0);
    vsync_in = 1'b0;
    model_clear();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nbad++;
    $display("FAIL R11 watchdog expired act=%0d exp=%0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    chk(word_valid == 1'b0 && word_out == '0, "R1", word_out, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(word_valid == 1'b0 && word_out == '0, "R1", word_out, 32'd0);

    // R7 / R2: LSB-first, rising edge
    set_cfg(7'b1000100);
    send4(32'h11223344, "R7");
    chk(word_out == 32'h44332211, "R7", word_out, 32'h44332211);
    // R8: MSB-first
    set_cfg(7'b1000110);
    send4(32'h11223344, "R8");
    chk(word_out == 32'h11223344, "R8", word_out, 32'h11223344);
    // R9: half swap on LSB-first
    set_cfg(7'b1000101);
    send4(32'h11223344, "R9");
    chk(word_out == 32'h22114433, "R9", word_out, 32'h22114433);
    // R2: falling-edge capture
    set_cfg(7'b0000100);
    send4(32'hA1B2C3D4, "R2");
    // R3: inverted pixel clock, both edge choices
    set_cfg(7'b1100100);
    send4(32'h0F1E2D3C, "R3");
    set_cfg(7'b0100110);
    send4(32'h55AA33CC, "R3");
    // R4: inverted data
    set_cfg(7'b1010100);
    send4(32'h11223344, "R4");
    chk(word_out == 32'hBBCCDDEE, "R4", word_out, 32'hBBCCDDEE);
    // R5 / R6: gated, active high, inactive bytes skipped
    set_cfg(7'b1001100);
    send_byte(8'h01, 1'b1, "R5");
    send_byte(8'h99, 1'b0, "R5");
    send_byte(8'h02, 1'b1, "R5");
    send_byte(8'h98, 1'b0, "R5");
    send_byte(8'h03, 1'b1, "R5");
    send_byte(8'h04, 1'b1, "R5");
    chk(word_out == 32'h04030201, "R5", word_out, 32'h04030201);
    // R6: active-low strobe
    set_cfg(7'b1001000);
    send_byte(8'h10, 1'b0, "R6");
    send_byte(8'hEE, 1'b1, "R6");
    send_byte(8'h20, 1'b0, "R6");
    send_byte(8'h30, 1'b0, "R6");
    send_byte(8'h40, 1'b0, "R6");
    chk(word_out == 32'h40302010, "R6", word_out, 32'h40302010);
    // R5: non-gated ignores the strobe level
    set_cfg(7'b1000100);
    send_byte(8'h5A, 1'b0, "R5");
    send_byte(8'h6B, 1'b1, "R5");
    send_byte(8'h7C, 1'b0, "R5");
    send_byte(8'h8D, 1'b0, "R5");
    chk(word_out == 32'h8D7C6B5A, "R5", word_out, 32'h8D7C6B5A);
    // R10: frame strobe mid-word realigns
    send_byte(8'hF1, 1'b1, "R10");
    send_byte(8'hF2, 1'b1, "R10");
    frame_pulse();
    send4(32'hC0C1C2C3, "R10");
    chk(word_out == 32'hC3C2C1C0, "R10", word_out, 32'hC3C2C1C0);
    // R12: enable low drops partial word and blocks captures
    send_byte(8'hE1, 1'b1, "R12");
    send_byte(8'hE2, 1'b1, "R12");
    @(negedge clk);
    enable = 1'b0;
    model_clear();
    send_byte(8'hE3, 1'b1, "R12");
    send_byte(8'hE4, 1'b1, "R12");
    send_byte(8'hE5, 1'b1, "R12");
    send_byte(8'hE6, 1'b1, "R12");
    chk(word_out == 32'hC3C2C1C0, "R12", word_out, 32'hC3C2C1C0);
    @(negedge clk);
    enable = 1'b1;
    send4(32'h01020304, "R12");
    chk(word_out == 32'h04030201, "R12", word_out, 32'h04030201);

    // random phase
    for (int i = 0; i < 800; i++) begin
      if (i % 37 == 0) set_cfg(7'($urandom));
      if (i % 53 == 0) frame_pulse();
      send_byte(8'($urandom), ($urandom % 4) != 0 ? cfg_hs_high : ~cfg_hs_high,
                cfg_msb_first ? "R8" : "R7");
    end

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule